// File: doc/BRIEF.md
# Strobe-Handshake Processor Bus Register Slave

This block lets an external 8-bit processor with a strobe-and-acknowledge bus read and write a small bank of byte registers held in the block. Every bus pin arrives without a clock relationship to the system. The block passes each one through two flip-flops and detects strobe edges on the synchronized copies.

A bus cycle has two phases. First the processor lowers the address strobe and the active-low chip select, places a 9-bit address on the bus, and raises the address strobe again. That rising edge captures the address, and the captured address stays in force until the next accepted capture. Next the processor sets the read/write level, low for a write, and lowers the data strobe. After a programmable settle count the block raises its acknowledge output. On a write it commits the synchronized data byte at that same moment. The processor then raises the data strobe, and the acknowledge falls.

Each write also appears on a one-cycle register-file write port, so that registers outside the bank can be updated. Reads take their value from the bank through a multiplexer that returns zero for addresses past the end of the bank. The data bus is carried as separate input, output and output-enable ports, and a tristate pad outside the block joins them.

Top module: `mbus_regif`

## Requirements
- R1: After synchronous reset, `rdy`, `d_oe` and `wr_stb` are 0, the captured address is 0 and every bank register holds 0.
- R2: The address is captured when the synchronized address strobe goes from low to high while the synchronized chip select is low. Later data-strobe cycles that have no new address phase reuse the captured address.
- R3: While chip select is high, address-strobe edges capture nothing and data-strobe falls start no cycle: `rdy` stays 0 and no register changes.
- R4: A cycle with `rw` = 0 is a write. In the clock cycle where `rdy` rises, `wr_stb` pulses for one cycle with `wr_addr` set to the captured address and `wr_data` set to `d_in`. The bank register at that address takes the new byte.
- R5: A cycle with `rw` = 1 is a read. `d_oe` is 1 from the start of the cycle until the cycle ends, and `d_out` holds the bank register at the captured address. `d_oe` is 0 on writes and while idle.
- R6: `rdy` rises exactly SETTLE_CYC + 3 clock edges after the data strobe falls: two edges to synchronize, one to detect the edge, and SETTLE_CYC edges of settle time.
- R7: `rdy` stays 1 while the data strobe is held low. It falls exactly 3 clock edges after the data strobe rises.
- R8: Each data-strobe assertion performs at most one write, however long the strobe is held low.
- R9: If the data strobe rises before `rdy` is asserted, the cycle is abandoned: there is no acknowledge and no write.
- R10: Captured addresses at or above NUM_REGS read as 0. Writes to them still pulse `wr_stb` with the full address, but they alter no bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low; its rising edge captures the address |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low; its falling edge starts a cycle |
| rw | input | 1 | Direction level: 0 write, 1 read |
| addr | input | 9 | Address bus |
| d_in | input | 8 | Data bus, inbound half |
| d_out | output | 8 | Data bus, outbound half |
| d_oe | output | 1 | Output enable for the data bus pad |
| rdy | output | 1 | Acknowledge, active high |
| wr_stb | output | 1 | One-cycle register-file write pulse |
| wr_addr | output | 9 | Register-file write address |
| wr_data | output | 8 | Register-file write data |

## Verification
The properties assume a processor that follows the handshake: the address, `rw` and `d_in` stay stable for the whole time their strobe is low, and the data strobe is not lowered again until `rdy` has fallen. The bench keeps to these rules. It changes the bus only on falling clock edges, holds each strobe for at least three clocks, and waits for the acknowledge to fall before it starts the next cycle. The abandoned-cycle case is the one deliberate exception, and even there `rw` and the data stay fixed.

// File: rtl/mbus_regif.sv
module mbus_regif #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic              rdy,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ADDR_W:0]  LIMIT = (ADDR_W + 1)'(NUM_REGS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_ACK} st_t;

  logic [1:0]        as_sy, cs_sy, ds_sy, rw_sy;
  logic [ADDR_W-1:0] a_m, a_s, a_lat;
  logic [DATA_W-1:0] d_m, d_s;
  logic              as_q, ds_q;
  logic              as_s, cs_s, ds_s, rw_s;
  logic              as_rise, ds_fall, in_range, rd_cyc;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] bank [NUM_REGS];
  st_t               st;

  assign as_s = as_sy[1];
  assign cs_s = cs_sy[1];
  assign ds_s = ds_sy[1];
  assign rw_s = rw_sy[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      as_sy <= 2'b11;
      cs_sy <= 2'b11;
      ds_sy <= 2'b11;
      rw_sy <= 2'b11;
      as_q  <= 1'b1;
      ds_q  <= 1'b1;
      a_m   <= '0;
      a_s   <= '0;
      d_m   <= '0;
      d_s   <= '0;
    end else begin
      as_sy <= {as_sy[0], as_n};
      cs_sy <= {cs_sy[0], cs_n};
      ds_sy <= {ds_sy[0], ds_n};
      rw_sy <= {rw_sy[0], rw};
      as_q  <= as_s;
      ds_q  <= ds_s;
      a_m   <= addr;
      a_s   <= a_m;
      d_m   <= d_in;
      d_s   <= d_m;
    end
  end

  assign as_rise  = as_s & ~as_q & ~cs_s;
  assign ds_fall  = ~ds_s & ds_q & ~cs_s;
  assign in_range = {1'b0, a_lat} < LIMIT;
  assign idx      = a_lat[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)          a_lat <= '0;
    else if (as_rise) a_lat <= a_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      rd_cyc  <= 1'b0;
      d_oe    <= 1'b0;
      rdy     <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      case (st)
        S_IDLE: if (ds_fall) begin
          st     <= S_SETTLE;
          cnt    <= '0;
          rd_cyc <= rw_s;
          d_oe   <= rw_s;
        end
        S_SETTLE: begin
          if (ds_s) begin
            st   <= S_IDLE;
            d_oe <= 1'b0;
          end else if (cnt == LAST) begin
            st  <= S_ACK;
            rdy <= 1'b1;
            if (!rd_cyc) begin
              wr_stb  <= 1'b1;
              wr_addr <= a_lat;
              wr_data <= d_s;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ACK: if (ds_s) begin
          st   <= S_IDLE;
          rdy  <= 1'b0;
          d_oe <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank[g] <= '0;
      else if (st == S_SETTLE && !ds_s && cnt == LAST && !rd_cyc && in_range
               && idx == IDX_W'(g))
        bank[g] <= d_s;
    end
  end

  assign d_out = in_range ? bank[idx] : '0;
endmodule

module mbus_regif_chk (
  input logic clk,
  input logic rst,
  input logic rdy,
  input logic d_oe,
  input logic wr_stb,
  input logic ds_s,
  input logic rd_cyc
);
  a_r4_write_with_ack: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $rose(rdy));
  a_r4_write_not_read: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !rd_cyc);
  a_r5_oe_on_read: assert property (@(posedge clk) disable iff (rst)
    d_oe |-> rd_cyc);
  a_r6_ack_while_low: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> !ds_s);
  a_r7_ack_hold: assert property (@(posedge clk) disable iff (rst)
    (rdy && !ds_s) |=> rdy);
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (rdy && ds_s) |=> !rdy);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

bind mbus_regif mbus_regif_chk u_chk (
  .clk(clk), .rst(rst), .rdy(rdy), .d_oe(d_oe),
  .wr_stb(wr_stb), .ds_s(ds_s), .rd_cyc(rd_cyc)
);

// File: tb/mbus_regif_test.sv
module mbus_regif_test;
  localparam int SETTLE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       as_n = 1'b1, cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] d_in = '0;
  logic [7:0] d_out;
  logic       d_oe, rdy, wr_stb;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [7:0]  rdq [$];
  logic [16:0] wrq [$];
  logic        rdy_q = 1'b0;

  mbus_regif #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst(rst), .as_n(as_n), .cs_n(cs_n), .ds_n(ds_n), .rw(rw),
    .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .rdy(rdy),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
    if (rdy && !rdy_q) begin
      if (d_oe) begin
        if (rdq.size() == 0) chk("R5 unexpected read", 1, 0);
        else chk("R5 read data", d_out, rdq.pop_front());
      end else if (wr_stb) begin
        if (wrq.size() == 0) chk("R4 unexpected write", 1, 0);
        else chk("R4 write port", {wr_addr, wr_data}, wrq.pop_front());
      end else begin
        chk("R4 ack without write or read", 1, 0);
      end
    end
    rdy_q = rdy;
  end

  task automatic set_addr(input logic [8:0] a, input logic cs);
    @(negedge clk);
    addr = a; cs_n = cs; as_n = 1'b0;
    repeat (3) @(negedge clk);
    as_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic xfer(input logic rw_v, input logic [7:0] dv, input logic cs,
                      input int hold, output int lat, output int drop,
                      output int pulses, output int oe_seen);
    lat = -1; drop = -1; pulses = 0; oe_seen = 0;
    @(negedge clk);
    cs_n = cs; rw = rw_v; d_in = dv; ds_n = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      pulses += int'(wr_stb);
      oe_seen = int'(d_oe);
      if (rdy) begin lat = n; break; end
    end
    repeat (hold) begin
      @(negedge clk);
      pulses += int'(wr_stb);
    end
    ds_n = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      pulses += int'(wr_stb);
      if (!rdy) begin drop = n; break; end
    end
    cs_n = 1'b1; rw = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] v, input string req);
    int lat, drop, p, oe;
    set_addr(a, 1'b0);
    wrq.push_back({a, v});
    xfer(1'b0, v, 1'b0, 0, lat, drop, p, oe);
    chk({req, " R6 latency"}, lat, SETTLE + 3);
    chk({req, " R7 drop"}, drop, 3);
    chk({req, " R5 no oe on write"}, oe, 0);
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    int lat, drop, p, oe;
    rdq.push_back(exp);
    xfer(1'b1, 8'h00, 1'b0, 0, lat, drop, p, oe);
    chk({req, " read acked"}, lat, SETTLE + 3);
    chk({req, " R5 oe during read"}, oe, 1);
    chk({req, " R5 oe off after"}, d_oe, 0);
  endtask

  initial begin
    int lat, drop, p, oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdy after reset", rdy, 0);
    chk("R1 oe after reset", d_oe, 0);
    chk("R1 wr_stb after reset", wr_stb, 0);
    do_read(8'h00, "R1 reg0 via reset address");

    do_write(9'd3, 8'hA5, "R4 reg3");
    do_write(9'd15, 8'h3C, "R4 reg15");
    do_write(9'd0, 8'h11, "R4 reg0");
    set_addr(9'd3, 1'b0);  do_read(8'hA5, "R2 reg3");
    set_addr(9'd15, 1'b0); do_read(8'hC3 ^ 8'hFF, "R2 reg15");
    set_addr(9'd0, 1'b0);  do_read(8'h11, "R2 reg0");
    do_read(8'h11, "R2 address retained");

    set_addr(9'd3, 1'b1);
    do_read(8'h11, "R3 capture ignored");
    xfer(1'b0, 8'hEE, 1'b1, 0, lat, drop, p, oe);
    chk("R3 no ack with cs high", lat, -1);
    chk("R3 no write pulse", p, 0);
    do_read(8'h11, "R3 reg0 unchanged");

    set_addr(9'd3, 1'b0);
    @(negedge clk);
    rw = 1'b0; d_in = 8'hFF; cs_n = 1'b0; ds_n = 1'b0;
    @(negedge clk);
    ds_n = 1'b1;
    p = 0; lat = 0;
    repeat (10) begin
      @(negedge clk);
      p += int'(wr_stb); lat += int'(rdy);
    end
    cs_n = 1'b1; rw = 1'b1;
    chk("R9 no ack on abandoned cycle", lat, 0);
    chk("R9 no write on abandoned cycle", p, 0);
    do_read(8'hA5, "R9 reg3 unchanged");

    set_addr(9'd7, 1'b0);
    wrq.push_back({9'd7, 8'h5A});
    xfer(1'b0, 8'h5A, 1'b0, 12, lat, drop, p, oe);
    chk("R8 single pulse on long strobe", p, 1);
    chk("R7 ack held then dropped", drop, 3);
    do_read(8'h5A, "R8 reg7 value");

    do_write(9'd12, 8'h12, "R4 reg12");
    do_write(9'd300, 8'h77, "R10 out of range");
    do_read(8'h00, "R10 out of range reads zero");
    set_addr(9'd12, 1'b0);
    do_read(8'h12, "R10 no alias into reg12");

    do_write(9'd3, 8'h4B, "R4 overwrite reg3");
    set_addr(9'd3, 1'b0);
    do_read(8'h4B, "R4 reg3 new value");

    repeat (4) @(negedge clk);
    chk("R4 write queue drained", wrq.size(), 0);
    chk("R5 read queue drained", rdq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule